// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous SRAM

This block is a single-port synchronous memory. Its address, write strobes and write data are captured on the rising clock edge, and its read path ends in an output register. An address sequencer in front of it supplies the word address and a flag that marks the cycle as an access. The processor or cache logic supplies the write controls, which are decoded in three levels. A global write stores the whole word. A byte-write gate passes or blocks the per-lane strobes, and each passed strobe stores one 9-bit lane, made of eight data bits and one parity bit.

Read data appears one clock after the address is captured. The output-drive indication is itself registered, so it falls one clock after a deselected cycle or a write cycle. A level-sensitive output-enable input can also force it low at any time. A sleep input freezes every register, as if the clock were stopped, and the stored contents are kept. The word is 36 bits (four lanes) or 18 bits (two lanes). The depth is a parameter and is kept small for simulation.

Top module: `pipe_bw_sram`

## Requirements
- R1: With `cycleValid` high and `globalWrN` low at a rising edge, all lanes of the addressed word are written, whatever `byteWrEnN` and `laneWrN` are.
- R2: With `globalWrN` high and `byteWrEnN` high, the lane strobes have no effect and the addressed word keeps its contents.
- R3: With `globalWrN` high and `byteWrEnN` low, each lane k (k = 0 upward) whose strobe `laneWrN[k]` is low is written, and several lanes may be written in one cycle. Lane k covers data bits [8k+7:8k] plus parity bit 8*LANES+k, which is bit 32+k for 36 bits and bit 16+k for 18 bits. All other bits keep their old value.
- R4: A read captured at rising edge E drives `rdData` with the stored word, and raises `rdDrive`, from edge E+1.
- R5: A cycle that writes any lane leaves `rdDrive` low from the following edge.
- R6: `outEnN` high forces `rdDrive` low at once, with no clock edge needed. `outEnN` low lets the registered drive state through.
- R7: After a read, a single deselected cycle captured at edge E makes `rdDrive` low from edge E+1.
- R8: While `sleepIn` is high, no register changes. `rdData` and `rdDrive` hold, accesses presented during sleep are discarded, and the array contents are retained.
- R9: In the 18-bit configuration, strobes `laneWrN[3:2]` are ignored.
- R10: A read captured in the cycle straight after a write to the same address returns the new lanes merged with the unwritten old lanes.
- R11: While `rstN` is low, `rdDrive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset of the control and pipeline registers |
| sleepIn | input | 1 | High: freeze all registers, keep contents |
| cycleValid | input | 1 | High: this cycle is an access (selected); low: deselected |
| addrIn | input | $clog2(DEPTH) | Word address from the sequencer |
| globalWrN | input | 1 | Active-low write of the whole word |
| byteWrEnN | input | 1 | Active-low gate for the lane strobes |
| laneWrN | input | 4 | Active-low per-lane write strobes |
| wrData | input | DATA_W | Write data, parity bits in the top LANES bits |
| outEnN | input | 1 | Level-sensitive active-low output enable |
| rdData | output | DATA_W | Registered read data |
| rdDrive | output | 1 | High when the data drivers would be enabled |

## Verification
The hardest situation to reach is a read whose address is captured in the very cycle a partial write to the same word is being committed. Only then do the new and old lanes of one word meet. The stimulus issues a two-lane write and, on the next clock, a read of the same address, then compares against a bench model that merges the lanes arithmetically. Sleep entry is the second awkward case. The bench puts the block to sleep while a read result is being driven and keeps presenting writes. It then checks that the output holds, and after waking with the block deselected, that the array was not touched.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  // Strobes passed from the control to the datapath each cycle.
  typedef struct packed {
    logic       capture;  // load address and write data registers
    logic       advance;  // clock not frozen: move the read pipeline
    logic [3:0] commit;   // lanes to write into the array this edge
  } strobe_t;
endpackage

// File: rtl/pbs_ctrl.sv
module pbs_ctrl
  import pbs_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepIn,
  input  logic       cycleValid,
  input  logic       globalWrN,
  input  logic       byteWrEnN,
  input  logic [3:0] laneWrN,
  input  logic       outEnN,
  output strobe_t    strb,
  output logic       rdDrive
);
  logic             awake;
  logic [LANES-1:0] laneReq;
  logic [LANES-1:0] laneQ;
  logic             selQ;
  logic             driveQ;

  assign awake = ~sleepIn;

  // Three-level write decode: global write, then gate, then lanes.
  always_comb begin
    if (!globalWrN)      laneReq = '1;
    else if (!byteWrEnN) laneReq = ~laneWrN[LANES-1:0];
    else                 laneReq = '0;
  end

  generate
    if (LANES < 4) begin : gNarrow
      logic unusedStrobes;
      assign unusedStrobes = ^laneWrN[3:LANES];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ   <= 1'b0;
      laneQ  <= '0;
      driveQ <= 1'b0;
    end else if (awake) begin
      selQ   <= cycleValid;
      laneQ  <= cycleValid ? laneReq : '0;
      driveQ <= selQ & ~(|laneQ);
    end
  end

  always_comb begin
    strb.capture = awake & cycleValid;
    strb.advance = awake;
    strb.commit  = '0;
    if (awake) strb.commit[LANES-1:0] = laneQ;
  end

  assign rdDrive = driveQ & ~outEnN;

  assert_gw_all_R1: assert property (@(posedge clk) disable iff (!rstN)
    (awake && cycleValid && !globalWrN) |=> (&laneQ));

  assert_gate_block_R2: assert property (@(posedge clk) disable iff (!rstN)
    (awake && globalWrN && byteWrEnN) |=> (laneQ == '0));

  assert_write_hiz_R5: assert property (@(posedge clk) disable iff (!rstN)
    (awake && (|laneQ)) |=> !driveQ);

  assert_deselect_R7: assert property (@(posedge clk) disable iff (!rstN)
    (awake && !cycleValid) ##1 awake |=> !driveQ);

  assert_sleep_drive_R8: assert property (@(posedge clk) disable iff (!rstN)
    sleepIn |=> $stable(driveQ));
endmodule

// File: rtl/pbs_datapath.sv
module pbs_datapath
  import pbs_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 36,
  localparam int LANES = DATA_W / 9,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [AW-1:0]     addrIn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int PAR_BASE = 8 * LANES;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] outQ;
  logic [DATA_W-1:0] laneBits;
  logic [DATA_W-1:0] curWord;
  logic [DATA_W-1:0] mergedWord;

  always_comb begin
    laneBits = '0;
    for (int l = 0; l < LANES; l++) begin
      if (strb.commit[l]) begin
        laneBits[8*l +: 8]     = 8'hFF;
        laneBits[PAR_BASE + l] = 1'b1;
      end
    end
  end

  assign curWord    = mem[addrQ];
  assign mergedWord = (curWord & ~laneBits) | (dataQ & laneBits);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (strb.capture) begin
      addrQ <= addrIn;
      dataQ <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (|strb.commit) mem[addrQ] <= mergedWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             outQ <= '0;
    else if (strb.advance) outQ <= curWord;
  end

  assign rdData = outQ;

  assert_sleep_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.advance |=> $stable(outQ));

  assert_no_commit_asleep_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.advance |-> (strb.commit == 4'b0));
endmodule

// File: rtl/pipe_bw_sram.sv
module pipe_bw_sram
  import pbs_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 36,
  localparam int LANES = DATA_W / 9,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleepIn,
  input  logic              cycleValid,
  input  logic [AW-1:0]     addrIn,
  input  logic              globalWrN,
  input  logic              byteWrEnN,
  input  logic [3:0]        laneWrN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              outEnN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive
);
  strobe_t strb;

  initial begin
    assert_width_cfg: assert (DATA_W == 36 || DATA_W == 18);
  end

  pbs_ctrl #(.LANES(LANES)) uCtrl (
    .clk(clk), .rstN(rstN), .sleepIn(sleepIn), .cycleValid(cycleValid),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .laneWrN(laneWrN),
    .outEnN(outEnN), .strb(strb), .rdDrive(rdDrive)
  );

  pbs_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .addrIn(addrIn),
    .wrData(wrData), .rdData(rdData)
  );

  assert_reset_drive_R11: assert property (@(posedge clk)
    !rstN |=> !rdDrive);
endmodule

// File: tb/tb_pipe_bw_sram.sv
module tb_pipe_bw_sram;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN, sleepIn, cycleValid, globalWrN, byteWrEnN, outEnN;
  logic [3:0]  addrIn, laneWrN;
  logic [35:0] wrData;
  logic [35:0] rd36;
  logic [17:0] rd18;
  logic        drv36, drv18;

  logic [35:0] exp36 [16];
  logic [17:0] exp18 [16];
  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  pipe_bw_sram #(.DEPTH(16), .DATA_W(36)) dut (
    .clk(clk), .rstN(rstN), .sleepIn(sleepIn), .cycleValid(cycleValid),
    .addrIn(addrIn), .globalWrN(globalWrN), .byteWrEnN(byteWrEnN),
    .laneWrN(laneWrN), .wrData(wrData), .outEnN(outEnN),
    .rdData(rd36), .rdDrive(drv36)
  );

  pipe_bw_sram #(.DEPTH(16), .DATA_W(18)) dut18 (
    .clk(clk), .rstN(rstN), .sleepIn(sleepIn), .cycleValid(cycleValid),
    .addrIn(addrIn), .globalWrN(globalWrN), .byteWrEnN(byteWrEnN),
    .laneWrN(laneWrN), .wrData(wrData[17:0]), .outEnN(outEnN),
    .rdData(rd18), .rdDrive(drv18)
  );

  function automatic logic [35:0] laneMask(input logic g, input logic b,
                                           input logic [3:0] l, input int lanes);
    logic [35:0] m = '0;
    for (int k = 0; k < lanes; k++) begin
      if (!g || (!b && !l[k])) begin
        m[8*k +: 8]     = 8'hFF;
        m[8*lanes + k]  = 1'b1;
      end
    end
    return m;
  endfunction

  function automatic logic [35:0] pat(input logic [3:0] a, input logic [35:0] s);
    return {a, a, a, a, a, a, a, a, a} ^ s;
  endfunction

  task automatic checkEq(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic g, input logic b,
                       input logic [3:0] l, input logic [3:0] a, input logic [35:0] d);
    logic [35:0] m36, m18;
    @(negedge clk);
    cycleValid = v; globalWrN = g; byteWrEnN = b; laneWrN = l;
    addrIn = a; wrData = d;
    if (v && !sleepIn) begin
      m36 = laneMask(g, b, l, 4);
      m18 = laneMask(g, b, l, 2);
      exp36[a] = (exp36[a] & ~m36) | (d & m36);
      exp18[a] = (exp18[a] & ~m18[17:0]) | (d[17:0] & m18[17:0]);
    end
  endtask

  task automatic idle();
    drive(1'b0, 1'b1, 1'b1, 4'hF, 4'h0, 36'h0);
  endtask

  task automatic readCheck(input logic [3:0] a, input string tag);
    drive(1'b1, 1'b1, 1'b1, 4'hF, a, 36'h0);
    idle();
    @(negedge clk);
    checkEq({tag, " drive36"}, 36'(drv36), 36'd1);
    checkEq({tag, " data36"}, rd36, exp36[a]);
    checkEq({tag, " drive18"}, 36'(drv18), 36'd1);
    checkEq({tag, " data18"}, 36'(rd18), 36'(exp18[a]));
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; sleepIn = 1'b0; outEnN = 1'b0;
    cycleValid = 1'b0; globalWrN = 1'b1; byteWrEnN = 1'b1; laneWrN = 4'hF;
    addrIn = '0; wrData = '0;
    repeat (3) @(negedge clk);
    checkEq("R11 reset drive36", 36'(drv36), 36'd0);
    checkEq("R11 reset drive18", 36'(drv18), 36'd0);
    rstN = 1'b1;

    // R1: fill with global write, strobe and gate values arbitrary
    for (int a = 0; a < 16; a++)
      drive(1'b1, 1'b0, a[0], a[3:0], a[3:0], pat(a[3:0], 36'h5A3C_96E1_7));
    for (int a = 0; a < 16; a++) readCheck(a[3:0], "R1");

    // R3 and R9: every lane strobe pattern, gate open
    for (int a = 0; a < 16; a++) begin
      drive(1'b1, 1'b1, 1'b0, a[3:0], a[3:0], pat(a[3:0], 36'hC_F00F_1234));
      readCheck(a[3:0], "R3/R9");
    end

    // R2: gate closed, all strobes active, nothing may change
    for (int a = 0; a < 16; a++) begin
      drive(1'b1, 1'b1, 1'b1, 4'h0, a[3:0], 36'hF_FFFF_FFFF);
      readCheck(a[3:0], "R2");
    end

    // R10: partial write then read of same word on the next clock
    drive(1'b1, 1'b1, 1'b0, 4'b1010, 4'd5, 36'h3_1122_3344);
    drive(1'b1, 1'b1, 1'b1, 4'hF, 4'd5, 36'h0);
    idle();
    @(negedge clk);
    checkEq("R10 merge36", rd36, exp36[5]);
    checkEq("R10 merge18", 36'(rd18), 36'(exp18[5]));

    // R7: one deselected cycle after a read
    readCheck(4'd9, "R4");
    @(negedge clk);
    checkEq("R7 deselect drive", 36'(drv36), 36'd0);

    // R4 then R5: read followed by a write cycle
    drive(1'b1, 1'b1, 1'b1, 4'hF, 4'd3, 36'h0);
    drive(1'b1, 1'b0, 1'b1, 4'hF, 4'd7, 36'h8_7654_3210);
    idle();
    checkEq("R4 read drive", 36'(drv36), 36'd1);
    checkEq("R4 read data", rd36, exp36[3]);
    @(negedge clk);
    checkEq("R5 write hiz", 36'(drv36), 36'd0);
    readCheck(4'd7, "R5 readback");

    // R6: asynchronous output enable
    drive(1'b1, 1'b1, 1'b1, 4'hF, 4'd1, 36'h0);
    idle();
    @(negedge clk);
    outEnN = 1'b1; #1;
    checkEq("R6 oe high", 36'(drv36), 36'd0);
    outEnN = 1'b0; #1;
    checkEq("R6 oe low", 36'(drv36), 36'd1);

    // R8: sleep while driving, writes presented are discarded
    drive(1'b1, 1'b1, 1'b1, 4'hF, 4'd2, 36'h0);
    idle();
    @(negedge clk);
    sleepIn = 1'b1;
    drive(1'b1, 1'b0, 1'b1, 4'h0, 4'd2, 36'hA_AAAA_AAAA);
    drive(1'b1, 1'b1, 1'b0, 4'h0, 4'd2, 36'h5_5555_5555);
    drive(1'b1, 1'b1, 1'b1, 4'hF, 4'd4, 36'h0);
    @(negedge clk);
    checkEq("R8 sleep drive", 36'(drv36), 36'd1);
    checkEq("R8 sleep data", rd36, exp36[2]);
    cycleValid = 1'b0; globalWrN = 1'b1; byteWrEnN = 1'b1; laneWrN = 4'hF;
    sleepIn = 1'b0;
    @(negedge clk);
    readCheck(4'd2, "R8 retained");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule